// File: doc/BRIEF.md
# Cache Line Lock Manager

This block holds the tags, valid bits and per-line lock bits of a small set-associative cache, 4 ways by 16 sets by default. It chooses a victim way whenever a line must be allocated. Data storage, writeback and bus timing belong to other blocks. Requests arrive one at a time as single-cycle pulses, and each result is registered and appears after the next rising clock edge.

Two kinds of request can set a lock. A core touch-and-lock request sets one when its cache-target flag selects this cache. A snoop write sets one when it lands in a programmed external-write window that has its lock attribute set. A burst snoop write that uses the write-allocate type also sets one. Several requests remove locks: a lock clear, a flush, a read-and-clear-lock snoop, and a flash clear. Two global mode inputs, one for instruction and one for data, stop core requests of that kind from allocating new lines. Snoop write allocations are not affected by these modes. If an allocation finds every way of its set locked, no line is allocated and a sticky overflow flag is set.

The address is a line address. The low bits select the set, and the rest form the tag. `rsp_lock` encodes the lock state as bit 1 for the instruction lock and bit 0 for the data lock.

Top module: `line_lock_mgr`

## Requirements
- R1: After reset no line is valid, `lock_ovf` is 0 and `rsp_valid` is 0.
- R2: A touch request (`req_op`=0) with `req_ct`=0 allocates nothing and changes no lock. It only reports hit and the current lock state of the line.
- R3: A touch request with `req_ct`=1 sets the instruction lock if `req_instr`=1 and the data lock otherwise. On a hit it sets the lock on the matching way. On a miss it allocates a way, writes the tag, sets valid and sets only that one lock bit.
- R4: The victim is the lowest-numbered invalid way. If every way is valid, the victim is the first unlocked way found by searching upward, with wrap-around, from the set's rotation pointer. After each allocation the pointer becomes victim+1, modulo the number of ways.
- R5: When an allocation finds every way of the set locked, nothing is allocated and `lock_ovf` is set. `lock_ovf` stays set until a cycle in which `ovf_clr` is 1 and no new overflow occurs.
- R6: A burst snoop write (`req_op`=2, `req_burst`=1) sets a data lock in either of two cases: its address lies inside a window (base ≤ addr ≤ limit) whose lock bit is set, or `req_wa`=1. It allocates on a miss. Otherwise it has no effect.
- R7: A non-burst snoop write sets a data lock, allocating on a miss, only when its address lies inside a window whose lock bit is set. `req_wa` is ignored for non-burst writes.
- R8: A lock clear (`req_op`=1) that hits clears both lock bits of the line. On a miss it changes nothing.
- R9: A flush (`req_op`=3) that hits invalidates the line and clears its locks. A read-and-clear-lock (`req_op`=4) that hits clears the locks and keeps the line valid.
- R10: While `gl_ilock`=1, an instruction touch that misses allocates nothing and does not set `lock_ovf`. `gl_dlock` does the same for data touches. Snoop write allocations ignore both inputs. A flash clear does not release these modes.
- R11: `flash_clr` zeroes every lock bit in one cycle and leaves tags and valid bits unchanged.
- R12: Each request pulse produces `rsp_valid`=1 exactly one clock later. `rsp_hit` reflects the lookup before the request. `rsp_alloc`, `rsp_way` and `rsp_lock` give the outcome. `rsp_way` is 0 when the request neither hits nor allocates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pulse |
| req_op | input | 3 | 0 touch, 1 lock clear, 2 snoop write, 3 flush, 4 read-and-clear-lock, others lookup only |
| req_addr | input | ADDR_W | Line address |
| req_ct | input | 1 | Touch targets this cache |
| req_instr | input | 1 | Touch is instruction type |
| req_burst | input | 1 | Snoop write is a burst |
| req_wa | input | 1 | Snoop write uses write-allocate type |
| flash_clr | input | 1 | Clear all lock bits |
| ovf_clr | input | 1 | Clear overflow flag |
| gl_ilock | input | 1 | Instruction allocation lock mode |
| gl_dlock | input | 1 | Data allocation lock mode |
| win_base | input | NWIN*ADDR_W | Window lower bounds |
| win_limit | input | NWIN*ADDR_W | Window upper bounds, inclusive |
| win_lock | input | NWIN | Window lock attribute |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_alloc | output | 1 | A way was allocated |
| rsp_way | output | log2(WAYS) | Hit or allocated way |
| rsp_lock | output | 2 | Resulting lock state {instr, data} |
| lock_ovf | output | 1 | Sticky lock overflow |

## Verification
A stale lock bit changes victim choice. The next allocation in that set then reports a different `rsp_way` in the response that follows it. A probe, which is a touch with the target flag clear, shows the lost or spurious bit directly in `rsp_lock`. A wrong valid or tag bit flips `rsp_hit` on the next request to that address. A rotation pointer error stays hidden until a set is full and holds at least two unlocked ways. Random traffic over a few sets and six tags fills sets quickly, so such errors reach `rsp_way` within a few requests. Overflow and mode errors show in `lock_ovf` and `rsp_alloc` in the cycle right after the request.

// File: rtl/line_lock_mgr.sv
module line_lock_mgr #(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int ADDR_W = 12,
  parameter int NWIN   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_ct,
  input  logic                     req_instr,
  input  logic                     req_burst,
  input  logic                     req_wa,
  input  logic                     flash_clr,
  input  logic                     ovf_clr,
  input  logic                     gl_ilock,
  input  logic                     gl_dlock,
  input  logic [NWIN*ADDR_W-1:0]   win_base,
  input  logic [NWIN*ADDR_W-1:0]   win_limit,
  input  logic [NWIN-1:0]          win_lock,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_alloc,
  output logic [$clog2(WAYS)-1:0]  rsp_way,
  output logic [1:0]               rsp_lock,
  output logic                     lock_ovf
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [2:0] OP_TOUCH = 3'd0, OP_CLR = 3'd1, OP_SWR = 3'd2,
                         OP_FLUSH = 3'd3, OP_RDCLR = 3'd4;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  ilk_q [SETS];
  logic [WAYS-1:0]  dlk_q [SETS];
  logic [WAY_W-1:0] rr_q  [SETS];

  wire [IDX_W-1:0] idx = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] tg  = req_addr[ADDR_W-1:IDX_W];
  wire [WAYS-1:0]  lk  = ilk_q[idx] | dlk_q[idx];

  logic             hit, free, win_lk;
  logic [WAY_W-1:0] hw, vic, cand;

  always_comb begin
    hit = 1'b0;
    hw  = '0;
    for (int w = 0; w < WAYS; w++)
      if (!hit && vld_q[idx][w] && tag_q[idx][w] == tg) begin
        hit = 1'b1;
        hw  = WAY_W'(w);
      end
  end

  always_comb begin
    free = 1'b0;
    vic  = '0;
    cand = '0;
    for (int w = 0; w < WAYS; w++)
      if (!free && !vld_q[idx][w]) begin
        free = 1'b1;
        vic  = WAY_W'(w);
      end
    for (int k = 0; k < WAYS; k++) begin
      cand = rr_q[idx] + WAY_W'(k);
      if (!free && !lk[cand]) begin
        free = 1'b1;
        vic  = cand;
      end
    end
  end

  always_comb begin
    win_lk = 1'b0;
    for (int n = 0; n < NWIN; n++)
      if (win_lock[n] && req_addr >= win_base[n*ADDR_W +: ADDR_W]
                      && req_addr <= win_limit[n*ADDR_W +: ADDR_W])
        win_lk = 1'b1;
  end

  wire is_touch = req_op == OP_TOUCH;
  wire is_swr   = req_op == OP_SWR;
  wire act      = (is_touch && req_ct) || (is_swr && (win_lk || (req_burst && req_wa)));
  wire lk_i     = is_touch && req_instr;
  wire blocked  = is_touch && (req_instr ? gl_ilock : gl_dlock);
  wire try_alloc = req_valid && act && !hit && !blocked;
  wire do_alloc  = try_alloc && free;
  wire ovf_set   = try_alloc && !free;
  wire clr_hit   = hit && (req_op == OP_CLR || req_op == OP_FLUSH || req_op == OP_RDCLR);
  wire [1:0] new_bit = lk_i ? 2'b10 : 2'b01;
  wire [1:0] cur     = {ilk_q[idx][hw], dlk_q[idx][hw]};

  logic [1:0] nxt_lock;
  always_comb begin
    nxt_lock = 2'b00;
    if (hit)           nxt_lock = clr_hit ? 2'b00 : (act ? cur | new_bit : cur);
    else if (do_alloc) nxt_lock = new_bit;
  end

  always_ff @(posedge clk)
    if (do_alloc) tag_q[idx][vic] <= tg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ilk_q[s] <= '0;
        dlk_q[s] <= '0;
        rr_q[s]  <= '0;
      end
      lock_ovf  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_alloc <= 1'b0;
      rsp_way   <= '0;
      rsp_lock  <= '0;
    end else begin
      if (req_valid && hit) begin
        ilk_q[idx][hw] <= nxt_lock[1];
        dlk_q[idx][hw] <= nxt_lock[0];
        if (req_op == OP_FLUSH) vld_q[idx][hw] <= 1'b0;
      end else if (do_alloc) begin
        vld_q[idx][vic] <= 1'b1;
        ilk_q[idx][vic] <= nxt_lock[1];
        dlk_q[idx][vic] <= nxt_lock[0];
        rr_q[idx]       <= vic + 1'b1;
      end
      if (flash_clr)
        for (int s = 0; s < SETS; s++) begin
          ilk_q[s] <= '0;
          dlk_q[s] <= '0;
        end
      if (ovf_set)      lock_ovf <= 1'b1;
      else if (ovf_clr) lock_ovf <= 1'b0;
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit;
      rsp_alloc <= do_alloc;
      rsp_way   <= !req_valid ? '0 : hit ? hw : do_alloc ? vic : '0;
      rsp_lock  <= req_valid ? nxt_lock : 2'b00;
    end
  end
endmodule

// File: rtl/line_lock_mgr_chk.sv
module line_lock_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       req_ct,
  input logic       ovf_clr,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       rsp_alloc,
  input logic [1:0] rsp_lock,
  input logic       lock_ovf
);
  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ovf && !ovf_clr) |=> lock_ovf);
  // R5
  ovf_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_ovf) |-> (rsp_valid && !rsp_alloc && !rsp_hit));
  // R2
  probe_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0 && !req_ct) |=> !rsp_alloc);
  // R8
  clear_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1) |=> rsp_lock == 2'b00);
  // R3
  alloc_one_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_alloc |-> (!rsp_hit && $onehot(rsp_lock)));
endmodule

bind line_lock_mgr line_lock_mgr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_ct(req_ct), .ovf_clr(ovf_clr), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_alloc(rsp_alloc), .rsp_lock(rsp_lock),
  .lock_ovf(lock_ovf));

// File: tb/test_line_lock_mgr.sv
module test_line_lock_mgr;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ct = 0, req_instr = 0, req_burst = 0, req_wa = 0;
  logic flash_clr = 0, ovf_clr = 0, gl_ilock = 0, gl_dlock = 0;
  logic [2:0] req_op = 0;
  logic [11:0] req_addr = 0;
  logic [23:0] win_base  = {12'h2ff, 12'h100};
  logic [23:0] win_limit = {12'h3ff, 12'h1ff};
  logic [1:0]  win_lock  = 2'b01;
  logic rsp_valid, rsp_hit, rsp_alloc, lock_ovf;
  logic [1:0] rsp_way, rsp_lock;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  line_lock_mgr i_line_lock_mgr (.*);

  bit [7:0] m_tag [16][4];
  bit [3:0] m_vld [16], m_ilk [16], m_dlk [16];
  bit [1:0] m_rr [16];
  bit m_ovf;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic bit in_lock_win(input logic [11:0] a);
    return (a >= 12'h100 && a <= 12'h1ff && win_lock[0]) ||
           (a >= 12'h2ff && a <= 12'h3ff && win_lock[1]);
  endfunction

  task automatic do_req(input bit [2:0] op, input bit [11:0] a, input bit ct, input bit ins,
                        input bit bu, input bit wa, input string r);
    bit [3:0] ix = a[3:0];
    bit [7:0] tg = a[11:4];
    bit h = 0, fr = 0, act, li, blk, tr;
    bit [1:0] hw = 0, vic = 0, el = 0, ew = 0;
    bit ea = 0;
    for (int w = 0; w < 4; w++)
      if (!h && m_vld[ix][w] && m_tag[ix][w] == tg) begin h = 1; hw = 2'(w); end
    for (int w = 0; w < 4; w++)
      if (!fr && !m_vld[ix][w]) begin fr = 1; vic = 2'(w); end
    for (int k = 0; k < 4; k++) begin
      bit [1:0] c = m_rr[ix] + 2'(k);
      if (!fr && !(m_ilk[ix][c] | m_dlk[ix][c])) begin fr = 1; vic = c; end
    end
    act = (op == 0 && ct) || (op == 2 && (in_lock_win(a) || (bu && wa)));
    li  = op == 0 && ins;
    blk = op == 0 && (ins ? gl_ilock : gl_dlock);
    tr  = act && !h && !blk;
    if (h) begin
      el = {m_ilk[ix][hw], m_dlk[ix][hw]};
      if (op == 1 || op == 3 || op == 4) el = 0;
      else if (act) el |= li ? 2'b10 : 2'b01;
      m_ilk[ix][hw] = el[1]; m_dlk[ix][hw] = el[0];
      if (op == 3) m_vld[ix][hw] = 0;
      ew = hw;
    end else if (tr && fr) begin
      ea = 1; ew = vic; el = li ? 2'b10 : 2'b01;
      m_tag[ix][vic] = tg; m_vld[ix][vic] = 1;
      m_ilk[ix][vic] = el[1]; m_dlk[ix][vic] = el[0];
      m_rr[ix] = vic + 2'd1;
    end else if (tr) m_ovf = 1;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_ct = ct;
    req_instr = ins; req_burst = bu; req_wa = wa;
    @(posedge clk); #1;
    req_valid = 0;
    chk(rsp_valid == 1, r, "rsp_valid", rsp_valid, 1);
    chk(rsp_hit == h, r, "rsp_hit", rsp_hit, h);
    chk(rsp_alloc == ea, r, "rsp_alloc", rsp_alloc, ea);
    chk(rsp_way == ew, r, "rsp_way", rsp_way, ew);
    chk(rsp_lock == el, r, "rsp_lock", rsp_lock, el);
    chk(lock_ovf == m_ovf, r, "lock_ovf", lock_ovf, m_ovf);
  endtask

  task automatic do_ctl(input bit fl, input bit oc, input string r);
    if (fl) for (int s = 0; s < 16; s++) begin m_ilk[s] = 0; m_dlk[s] = 0; end
    if (oc) m_ovf = 0;
    @(negedge clk);
    flash_clr = fl; ovf_clr = oc;
    @(posedge clk); #1;
    flash_clr = 0; ovf_clr = 0;
    chk(rsp_valid == 0, r, "rsp_valid idle", rsp_valid, 0);
    chk(lock_ovf == m_ovf, r, "lock_ovf", lock_ovf, m_ovf);
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(0, "WDOG", "timeout", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [7:0] tags [6] = '{8'h01, 8'h02, 8'h10, 8'h14, 8'h20, 8'h30};
    int unused = $urandom(32'd1357);
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    chk(lock_ovf == 0, "R1", "lock_ovf", lock_ovf, 0);
    rst_n = 1;
    do_req(0, 12'h015, 0, 0, 0, 0, "R1");
    do_req(0, 12'h015, 0, 0, 0, 0, "R2");
    do_req(0, 12'h010, 1, 0, 0, 0, "R3");
    do_req(0, 12'h010, 1, 1, 0, 0, "R3");
    do_req(0, 12'h010, 0, 0, 0, 0, "R2");
    do_req(0, 12'h020, 1, 1, 0, 0, "R4");
    do_req(0, 12'h030, 1, 0, 0, 0, "R4");
    do_req(0, 12'h040, 1, 0, 0, 0, "R4");
    do_req(0, 12'h050, 1, 0, 0, 0, "R5");
    do_req(0, 12'h020, 0, 0, 0, 0, "R5");
    do_ctl(0, 1, "R5");
    do_req(1, 12'h030, 0, 0, 0, 0, "R8");
    do_req(1, 12'h070, 0, 0, 0, 0, "R8");
    do_req(1, 12'h010, 0, 0, 0, 0, "R8");
    do_req(0, 12'h050, 1, 0, 0, 0, "R4");
    do_req(0, 12'h060, 1, 0, 0, 0, "R4");
    do_req(3, 12'h020, 0, 0, 0, 0, "R9");
    do_req(0, 12'h020, 0, 0, 0, 0, "R9");
    do_req(4, 12'h040, 0, 0, 0, 0, "R9");
    do_req(0, 12'h040, 0, 0, 0, 0, "R9");
    gl_dlock = 1;
    do_req(0, 12'h081, 1, 0, 0, 0, "R10");
    do_req(0, 12'h091, 1, 1, 0, 0, "R10");
    do_req(2, 12'h0a1, 0, 0, 1, 1, "R10");
    do_ctl(1, 0, "R11");
    do_req(0, 12'h0a1, 0, 0, 0, 0, "R11");
    do_req(0, 12'h0b1, 1, 0, 0, 0, "R10");
    gl_dlock = 0; gl_ilock = 1;
    do_req(0, 12'h0c1, 1, 1, 0, 0, "R10");
    do_req(0, 12'h0c1, 1, 0, 0, 0, "R10");
    gl_ilock = 0;
    do_req(2, 12'h102, 0, 0, 0, 0, "R7");
    do_req(2, 12'h052, 0, 0, 0, 1, "R7");
    do_req(2, 12'h062, 0, 0, 1, 1, "R6");
    do_req(2, 12'h302, 0, 0, 1, 0, "R6");
    do_req(2, 12'h112, 0, 0, 1, 0, "R6");
    do_req(2, 12'h072, 0, 0, 1, 0, "R6");
    for (int i = 0; i < 3000; i++) begin
      int p = $urandom % 100;
      bit [11:0] a = {tags[$urandom % 6], 4'($urandom % 3)};
      bit [2:0] op = 3'($urandom % 6);
      if (p < 3) do_ctl(1, 0, "R11");
      else if (p < 6) do_ctl(0, 1, "R5");
      else begin
        if (p < 9) begin gl_ilock = $urandom % 2; gl_dlock = $urandom % 2; end
        do_req(op, a, $urandom % 4 != 0, $urandom % 2, $urandom % 2, $urandom % 2, "R12");
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule